// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block gathers 32 interrupt inputs and turns them into two request lines and one wakeup flag for a processor. Each source has a three-bit trigger code, built from one bit of each of three configuration words. The code selects disabled, rising edge, falling edge, both edges, high level or low level. An edge event is held in a per-source latch until software clears it. A level source follows its input directly.

Software reaches every control word (three configuration words, a source-select word, a routing word, a wakeup-enable word and a mask word) through two word addresses in a 256-byte window. Writing at the first address ORs the written ones into the word. Writing at the second address clears the bits where the data has ones. Two of the clear addresses return request status on a read instead of the stored word. A pending, unmasked source goes to request line 0 or request line 1, as its routing bit selects. The wakeup flag does not depend on the mask.

Top module: `sic_top`

## Requirements
- R1: A write at a set address (0x40 cfg0, 0x48 cfg1, 0x50 cfg2, 0x58 source, 0x60 routing, 0x68 mask, 0x78 wakeup-enable) ORs the write data into that word.
- R2: A write at a clear address (the set address + 4) clears every bit of the word for which the write data bit is 1 and leaves the other bits unchanged.
- R3: A read returns its data one cycle after bus_rd. At a set address it returns the word. At the clear address of cfg0, cfg1, routing, mask or wakeup-enable it also returns the word.
- R4: A read at 0x54 returns the request-0 status, which is pending & mask & routing. A read at 0x5C returns the request-1 status, which is pending & mask & ~routing.
- R5: A write at an undecoded offset changes no word. A read at an undecoded offset returns 0.
- R6: Synchronous reset clears all words, the edge latches, bus_rdata, req0_o, req1_o and wake_o.
- R7: Trigger code {cfg2,cfg1,cfg0} = 4 makes the source pending while its input is high. Code 5 makes it pending while its input is low. Neither code latches.
- R8: Codes 1 (rising), 2 (falling) and 3 (both edges) latch the event. The latch holds after the input returns, until a write of 1 to that bit at 0x54. An event in the same cycle as the clear wins.
- R9: Codes 0, 6 and 7 never make a source pending.
- R10: A pending source with mask bit 1 drives req0_o when its routing bit is 1 and drives req1_o when its routing bit is 0.
- R11: wake_o is high when any pending source has its wakeup-enable bit set, whatever its mask bit.
- R12: req0_o, req1_o and wake_o are registered. They follow a register write or a level change on the next clock edge, and an input edge on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_in | input | 32 | Raw interrupt inputs |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup flag |

## Verification
The bench aims at the two aliased clear addresses. A design that decodes 0x54 or 0x5C like the other clear addresses would return cfg2 or the source word where request status is expected. A latch that follows the input instead of holding would drop a rising-edge request as soon as the input falls. A latch that ignores the clear would never let the request fall. The bench also covers trigger code 6, which a loose decoder would read as a level mode. It covers a masked source with wakeup enabled, where a design that gates wakeup with the mask would keep wake_o low. It checks the cycle in which the outputs move, which catches a missing or extra output register stage.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int unsigned NUM_REGS = 7;

  typedef enum logic [2:0] {
    RI_CFG0 = 3'd0,
    RI_CFG1 = 3'd1,
    RI_CFG2 = 3'd2,
    RI_SRC  = 3'd3,
    RI_ASGN = 3'd4,
    RI_WAKE = 3'd5,
    RI_MASK = 3'd6
  } reg_idx_e;

  localparam logic [2:0] TM_OFF  = 3'd0;
  localparam logic [2:0] TM_RISE = 3'd1;
  localparam logic [2:0] TM_FALL = 3'd2;
  localparam logic [2:0] TM_BOTH = 3'd3;
  localparam logic [2:0] TM_HIGH = 3'd4;
  localparam logic [2:0] TM_LOW  = 3'd5;

  localparam logic [7:0] OFF_REQ0_STAT = 8'h54;
  localparam logic [7:0] OFF_REQ1_STAT = 8'h5C;

  function automatic logic [7:0] set_offset(int unsigned idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h48;
      2:       return 8'h50;
      3:       return 8'h58;
      4:       return 8'h60;
      5:       return 8'h78;
      6:       return 8'h68;
      default: return 8'hFC;
    endcase
  endfunction

  function automatic logic [7:0] clr_offset(int unsigned idx);
    return set_offset(idx) + 8'h04;
  endfunction

endpackage

// File: rtl/sic_regbank.sv
module sic_regbank
  import sic_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [NUM_REGS-1:0][DW-1:0]   regs,
  output logic [DW-1:0]                 edge_clr
);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    localparam logic [AW-1:0] SET_A = AW'(set_offset(k));
    localparam logic [AW-1:0] CLR_A = AW'(clr_offset(k));
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (wr && addr == SET_A) begin
        word_q <= word_q | wdata;
      end else if (wr && addr == CLR_A) begin
        word_q <= word_q & ~wdata;
      end
    end

    assign regs[k] = word_q;
  end

  localparam logic [AW-1:0] EDGE_CLR_A = AW'(clr_offset(int'(RI_CFG2)));

  assign edge_clr = (wr && addr == EDGE_CLR_A) ? wdata : '0;

endmodule

// File: rtl/sic_trigger.sv
module sic_trigger
  import sic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] cfg0,
  input  logic [N-1:0] cfg1,
  input  logic [N-1:0] cfg2,
  input  logic [N-1:0] edge_clr,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic       prev_q;
    logic       lat_q;
    logic [2:0] mode;
    logic       rise;
    logic       fall;
    logic       evt;

    assign mode = {cfg2[i], cfg1[i], cfg0[i]};
    assign rise = irq_in[i] & ~prev_q;
    assign fall = ~irq_in[i] & prev_q;

    always_comb begin
      case (mode)
        TM_RISE: evt = rise;
        TM_FALL: evt = fall;
        TM_BOTH: evt = rise | fall;
        default: evt = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (evt) begin
          lat_q <= 1'b1;
        end else if (edge_clr[i]) begin
          lat_q <= 1'b0;
        end
      end
    end

    always_comb begin
      case (mode)
        TM_RISE, TM_FALL, TM_BOTH: pend[i] = lat_q;
        TM_HIGH:                   pend[i] = irq_in[i];
        TM_LOW:                    pend[i] = ~irq_in[i];
        default:                   pend[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] asgn,
  input  logic [N-1:0] wake_en,
  output logic [N-1:0] req0_stat,
  output logic [N-1:0] req1_stat,
  output logic         req0_o,
  output logic         req1_o,
  output logic         wake_o
);

  logic [N-1:0] live;

  assign live      = pend & mask;
  assign req0_stat = live & asgn;
  assign req1_stat = live & ~asgn;

  always_ff @(posedge clk) begin
    if (rst) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      req0_o <= |req0_stat;
      req1_o <= |req1_stat;
      wake_o <= |(pend & wake_en);
    end
  end

endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 32,
  parameter int unsigned WINDOW_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [$clog2(WINDOW_BYTES)-1:0] bus_addr,
  input  logic [NUM_SRC-1:0]            bus_wdata,
  output logic [NUM_SRC-1:0]            bus_rdata,
  input  logic [NUM_SRC-1:0]            irq_in,
  output logic                          req0_o,
  output logic                          req1_o,
  output logic                          wake_o
);

  localparam int unsigned AW = $clog2(WINDOW_BYTES);
  localparam int unsigned DW = NUM_SRC;

  logic [NUM_REGS-1:0][DW-1:0] regs;
  logic [DW-1:0]               edge_clr;
  logic [DW-1:0]               pend;
  logic [DW-1:0]               req0_stat;
  logic [DW-1:0]               req1_stat;
  logic [DW-1:0]               rd_mux;

  sic_regbank #(.DW(DW), .AW(AW)) u_regbank (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .regs     (regs),
    .edge_clr (edge_clr)
  );

  sic_trigger #(.N(DW)) u_trigger (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .cfg0     (regs[RI_CFG0]),
    .cfg1     (regs[RI_CFG1]),
    .cfg2     (regs[RI_CFG2]),
    .edge_clr (edge_clr),
    .pend     (pend)
  );

  sic_route #(.N(DW)) u_route (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .mask      (regs[RI_MASK]),
    .asgn      (regs[RI_ASGN]),
    .wake_en   (regs[RI_WAKE]),
    .req0_stat (req0_stat),
    .req1_stat (req1_stat),
    .req0_o    (req0_o),
    .req1_o    (req1_o),
    .wake_o    (wake_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (bus_addr == AW'(set_offset(k))) begin
        rd_mux = regs[k];
      end else if (bus_addr == AW'(clr_offset(k)) &&
                   k != int'(RI_CFG2) && k != int'(RI_SRC)) begin
        rd_mux = regs[k];
      end
    end
    if (bus_addr == AW'(OFF_REQ0_STAT)) rd_mux = req0_stat;
    if (bus_addr == AW'(OFF_REQ1_STAT)) rd_mux = req1_stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/sic_chk.sv
module sic_chk
  import sic_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic [AW-1:0]               bus_addr,
  input logic [DW-1:0]               bus_wdata,
  input logic [DW-1:0]               bus_rdata,
  input logic [NUM_REGS-1:0][DW-1:0] regs,
  input logic                        req0_o,
  input logic                        req1_o,
  input logic                        wake_o
);

  p_reset_clean_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regs == '0 && bus_rdata == '0 && !req0_o && !req1_o && !wake_o));

  p_set_or_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8'h68)) |=>
      ((regs[RI_MASK] & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((regs[RI_MASK] & $past(regs[RI_MASK])) == $past(regs[RI_MASK])));

  p_clr_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8'h44)) |=>
      ((regs[RI_CFG0] & $past(bus_wdata)) == '0) &&
      (regs[RI_CFG0] == ($past(regs[RI_CFG0]) & ~$past(bus_wdata))));

  p_undecoded_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8'h00)) |=> $stable(regs));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (regs[RI_MASK] == '0) |=> (!req0_o && !req1_o));

  p_wake_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (regs[RI_WAKE] == '0) |=> !wake_o);

endmodule

bind sic_top sic_chk #(.DW(NUM_SRC), .AW($clog2(WINDOW_BYTES))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .regs      (regs),
  .req0_o    (req0_o),
  .req1_o    (req1_o),
  .wake_o    (wake_o)
);

// File: tb/sic_top_bench.sv
`timescale 1ns/1ps
module sic_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        req0_o;
  logic        req1_o;
  logic        wake_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  logic     rd_seen = 1'b0;

  always #4 clk = ~clk;

  sic_top u_sic_top (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .req0_o    (req0_o),
    .req1_o    (req1_o),
    .wake_o    (wake_o)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      n_tests++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h",
                 it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_out(input logic e0, input logic e1, input logic ew, input string tag);
    n_tests++;
    if (req0_o !== e0 || req1_o !== e1 || wake_o !== ew) begin
      n_fail++;
      $display("FAIL %s outputs req0/req1/wake: actual %b%b%b expected %b%b%b",
               tag, req0_o, req1_o, wake_o, e0, e1, ew);
    end
  endtask

  task automatic wipe();
    irq_in = '0;
    settle();
    for (int k = 0; k < 7; k++) begin
      case (k)
        0: wr(8'h44, 32'hFFFF_FFFF);
        1: wr(8'h4C, 32'hFFFF_FFFF);
        2: wr(8'h54, 32'hFFFF_FFFF);
        3: wr(8'h5C, 32'hFFFF_FFFF);
        4: wr(8'h64, 32'hFFFF_FFFF);
        5: wr(8'h6C, 32'hFFFF_FFFF);
        default: wr(8'h7C, 32'hFFFF_FFFF);
      endcase
    end
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R6: reset state
    chk_out(1'b0, 1'b0, 1'b0, "R6");
    rd_expect(8'h40, 32'h0, "R6");
    rd_expect(8'h68, 32'h0, "R6");
    rd_expect(8'h78, 32'h0, "R6");

    // R1 / R2 / R3: set and clear aliases
    wr(8'h40, 32'h0000_00A5);
    wr(8'h40, 32'h0000_0F00);
    rd_expect(8'h40, 32'h0000_0FA5, "R1");
    wr(8'h44, 32'h0000_0105);
    rd_expect(8'h44, 32'h0000_0EA0, "R2");
    wr(8'h60, 32'h1234_0000);
    rd_expect(8'h64, 32'h1234_0000, "R3");
    wr(8'h58, 32'h0000_00F0);
    rd_expect(8'h58, 32'h0000_00F0, "R3");
    wipe();

    // R5: undecoded offsets
    wr(8'h68, 32'h0000_0011);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd_expect(8'h68, 32'h0000_0011, "R5");
    rd_expect(8'h70, 32'h0, "R5");
    rd_expect(8'h00, 32'h0, "R5");
    wipe();

    // R7 / R10 / R4: high level, routed to request 0
    wr(8'h50, 32'h0000_0008);
    wr(8'h60, 32'h0000_0008);
    wr(8'h68, 32'h0000_0008);
    irq_in[3] = 1'b1;
    settle();
    chk_out(1'b1, 1'b0, 1'b0, "R7 high level");
    rd_expect(8'h54, 32'h0000_0008, "R4 req0 status");
    rd_expect(8'h5C, 32'h0, "R4 req1 status");
    rd_expect(8'h50, 32'h0000_0008, "R3 cfg2 set read");
    wr(8'h64, 32'h0000_0008);
    settle();
    chk_out(1'b0, 1'b1, 1'b0, "R10 route to req1");
    rd_expect(8'h5C, 32'h0000_0008, "R4 req1 status");
    irq_in[3] = 1'b0;
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R7 level not held");
    wipe();

    // R7: low level
    wr(8'h50, 32'h0000_0010);
    wr(8'h40, 32'h0000_0010);
    wr(8'h68, 32'h0000_0010);
    irq_in[4] = 1'b1;
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R7 low level idle");
    irq_in[4] = 1'b0;
    settle();
    chk_out(1'b0, 1'b1, 1'b0, "R7 low level active");
    wipe();

    // R8 / R12: rising edge latch and clear
    wr(8'h40, 32'h0000_0080);
    wr(8'h60, 32'h0000_0080);
    wr(8'h68, 32'h0000_0080);
    @(negedge clk);
    irq_in[7] = 1'b1;
    @(negedge clk);
    chk_out(1'b0, 1'b0, 1'b0, "R12 edge not yet");
    @(negedge clk);
    chk_out(1'b1, 1'b0, 1'b0, "R12 edge second edge");
    irq_in[7] = 1'b0;
    settle();
    chk_out(1'b1, 1'b0, 1'b0, "R8 rising latched");
    rd_expect(8'h54, 32'h0000_0080, "R8 status");
    wr(8'h54, 32'h0000_0080);
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R8 cleared");
    rd_expect(8'h40, 32'h0000_0080, "R8 cfg0 kept");
    wipe();

    // R8: falling edge only
    wr(8'h48, 32'h0000_0100);
    wr(8'h68, 32'h0000_0100);
    irq_in[8] = 1'b1;
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R8 falling ignores rise");
    irq_in[8] = 1'b0;
    settle();
    chk_out(1'b0, 1'b1, 1'b0, "R8 falling latched");
    wipe();

    // R8: both edges
    wr(8'h40, 32'h0000_0200);
    wr(8'h48, 32'h0000_0200);
    wr(8'h60, 32'h0000_0200);
    wr(8'h68, 32'h0000_0200);
    irq_in[9] = 1'b1;
    settle();
    chk_out(1'b1, 1'b0, 1'b0, "R8 both rise");
    wr(8'h54, 32'h0000_0200);
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R8 both cleared");
    irq_in[9] = 1'b0;
    settle();
    chk_out(1'b1, 1'b0, 1'b0, "R8 both fall");
    wipe();

    // R9: code 6 and code 0 never pending
    wr(8'h50, 32'h0000_0400);
    wr(8'h48, 32'h0000_0400);
    wr(8'h60, 32'h0000_0C00);
    wr(8'h68, 32'h0000_0C00);
    wr(8'h78, 32'h0000_0C00);
    irq_in[10] = 1'b1;
    irq_in[11] = 1'b1;
    settle();
    chk_out(1'b0, 1'b0, 1'b0, "R9 disabled codes");
    rd_expect(8'h54, 32'h0, "R9 status");
    wipe();

    // R11 / R12: wakeup ignores mask; output follows mask write by one edge
    wr(8'h50, 32'h0000_0008);
    wr(8'h60, 32'h0000_0008);
    wr(8'h78, 32'h0000_0008);
    irq_in[3] = 1'b1;
    settle();
    chk_out(1'b0, 1'b0, 1'b1, "R11 wake while masked");
    rd_expect(8'h7C, 32'h0000_0008, "R3 wake clear read");
    wr(8'h68, 32'h0000_0008);
    chk_out(1'b0, 1'b0, 1'b1, "R12 mask write same edge");
    @(negedge clk);
    chk_out(1'b1, 1'b0, 1'b1, "R12 mask write next edge");
    wipe();

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule